// File: doc/BRIEF.md
# Parallel Panel Write Engine

This block sends a frame of pixel words to a display panel that keeps its own frame memory, over a parallel bus with one chip-select and one write strobe. Each bus write has four phases, and software sets the length of each one in a configuration word. The block latches these lengths when a frame starts. It takes words from a streaming pixel source with a valid/ready handshake. It drives chip-select and the write strobe for each word and counts the words until it has sent width times height of them.

A frame starts in one of two ways. Software can write a trigger command, or a rising edge on the panel's tearing-effect (TE) line can start it. The TE start can fire once after being armed, or on every TE pulse. No request is taken while a frame is in flight; the block leaves the busy state only on frame completion. Completion gives a single-cycle done pulse and a sticky done flag. Software clears the flag by pulsing a clear input.

Top module: `i80_wr_engine`

## Requirements
- R1: After reset, cs_n and wr_n are high, pix_ready, busy, done_pulse and done_flag are low, the interface is disabled, the write-active count is 1 and the other three counts are 0.
- R2: Configuration bit positions: bit 0 enables the interface, bits 7:4 are the hold count, 11:8 the active count, 15:12 the write-setup count and 19:16 the chip-select setup count. cfg_be[n] enables the write of byte n. While bit 0 is clear, every trigger is ignored.
- R3: For setup C, write setup W, active A and hold H, each word holds cs_n low for C+W+A+1+H consecutive cycles, with wr_n low for exactly A+1 of them. A phase whose count is 0 is skipped. wr_n is never low while cs_n is high. bus_data is steady while cs_n is low.
- R4: pix_ready is high only between words, while cs_n and wr_n are both high. Each handshake takes exactly one word. Words reach the bus in arrival order, and a source that stalls only delays the frame.
- R5: A frame is frm_w*frm_h words. A trigger is ignored if that product is zero.
- R6: A trigger-register write with both bit 0 (software mode) and bit 1 (command) set starts a frame. A write with bit 1 set and bit 0 clear is ignored.
- R7: With stored trigger bits 3 (TE enable) and 4 (TE unmask) set and bit 0 clear, a rising edge of te_in starts a frame. If bit 3 or bit 4 is clear, or bit 0 is set, TE is ignored. With bit 31 clear, the TE start fires once per trigger-register write.
- R8: With bit 31 set as well, every TE rising edge that arrives while the block is idle starts a frame.
- R9: Triggers and TE edges that arrive while busy are dropped and never queued. busy falls only when a frame completes.
- R10: done_pulse lasts one cycle and comes in the cycle in which busy falls. done_flag sets with it and stays set until done_clr. A completion in the same cycle as done_clr wins.
- R11: The timing counts are latched when a frame starts, so configuration writes during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the configuration write |
| cfg_wdata | input | 32 | Configuration word |
| trg_wr | input | 1 | Trigger-register write strobe |
| trg_wdata | input | 32 | Trigger word: mode, command, TE enable, unmask, repeat |
| frm_w | input | DIMW | Frame width in words |
| frm_h | input | DIMW | Frame height in lines |
| te_in | input | 1 | Tearing-effect line from the panel |
| pix_data | input | DW | Pixel word from the source |
| pix_valid | input | 1 | Source has a word |
| pix_ready | output | 1 | Engine takes a word |
| cs_n | output | 1 | Panel chip-select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| bus_data | output | DW | Panel data bus |
| busy | output | 1 | Frame in flight |
| done_pulse | output | 1 | One-cycle frame completion |
| done_flag | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Clears done_flag |

## Verification
A trigger sampled at a clock edge puts the engine in its word-fetch state at that same edge. Chip-select falls at the edge after the handshake, and done_pulse rises at the edge after the last active or hold cycle, together with the fall of busy. Because of this fixed timing, the bench measures low-cycle totals of cs_n and wr_n with a falling-edge monitor. It compares each word on the bus when wr_n rises, and it allows a few settling cycles after completion before it reads the totals. For tests where a request must be ignored, the bench waits a fixed window longer than any frame and checks that no strobe and no done pulse appeared.

// File: rtl/i80_wr_engine.sv
module i80_wr_engine #(
  parameter int DW   = 16,
  parameter int DIMW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [3:0]      cfg_be,
  input  logic [31:0]     cfg_wdata,
  input  logic            trg_wr,
  input  logic [31:0]     trg_wdata,
  input  logic [DIMW-1:0] frm_w,
  input  logic [DIMW-1:0] frm_h,
  input  logic            te_in,
  input  logic [DW-1:0]   pix_data,
  input  logic            pix_valid,
  output logic            pix_ready,
  output logic            cs_n,
  output logic            wr_n,
  output logic [DW-1:0]   bus_data,
  output logic            busy,
  output logic            done_pulse,
  output logic            done_flag,
  input  logic            done_clr
);
  localparam int CNTW = 2 * DIMW;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CSS, S_WSU, S_ACT, S_HOLD} st_t;

  st_t            st, nst;
  logic [3:0]     cnt, ncnt;
  logic [CNTW-1:0] left;
  logic [CNTW-1:0] frame_n;
  logic           en_q;
  logic [3:0]     c_cs, c_ws, c_act, c_hold;
  logic [3:0]     t_cs, t_ws, t_act, t_hold;
  logic           tm_sw, tm_hwen, tm_unmask, tm_rep, hw_arm;
  logic           te_q;
  logic           sw_fire, hw_fire, start, fin, last;
  logic [DW-1:0]  bus_q;
  logic           unused_bits;

  assign unused_bits = ^{cfg_wdata[31:20], cfg_wdata[3:1], cfg_be[3],
                         trg_wdata[30:5], trg_wdata[2]};

  assign frame_n = CNTW'(frm_w) * CNTW'(frm_h);
  assign sw_fire = trg_wr & trg_wdata[1] & trg_wdata[0];
  assign hw_fire = te_in & ~te_q & tm_hwen & tm_unmask & ~tm_sw & (tm_rep | hw_arm);
  assign start   = (st == S_IDLE) & en_q & (sw_fire | hw_fire) & (frame_n != '0);
  assign last    = (left == CNTW'(1));

  assign pix_ready = (st == S_LOAD);
  assign cs_n      = ~(st == S_CSS || st == S_WSU || st == S_ACT || st == S_HOLD);
  assign wr_n      = ~(st == S_ACT);
  assign bus_data  = bus_q;
  assign busy      = (st != S_IDLE);

  always_comb begin
    nst  = st;
    ncnt = cnt;
    fin  = 1'b0;
    case (st)
      S_IDLE: if (start) nst = S_LOAD;
      S_LOAD:
        if (pix_valid) begin
          if (t_cs != 4'd0) begin
            nst = S_CSS; ncnt = t_cs - 4'd1;
          end else if (t_ws != 4'd0) begin
            nst = S_WSU; ncnt = t_ws - 4'd1;
          end else begin
            nst = S_ACT; ncnt = t_act;
          end
        end
      S_CSS:
        if (cnt != 4'd0) ncnt = cnt - 4'd1;
        else if (t_ws != 4'd0) begin
          nst = S_WSU; ncnt = t_ws - 4'd1;
        end else begin
          nst = S_ACT; ncnt = t_act;
        end
      S_WSU:
        if (cnt != 4'd0) ncnt = cnt - 4'd1;
        else begin
          nst = S_ACT; ncnt = t_act;
        end
      S_ACT:
        if (cnt != 4'd0) ncnt = cnt - 4'd1;
        else if (t_hold != 4'd0) begin
          nst = S_HOLD; ncnt = t_hold - 4'd1;
        end else fin = 1'b1;
      S_HOLD:
        if (cnt != 4'd0) ncnt = cnt - 4'd1;
        else fin = 1'b1;
      default: nst = S_IDLE;
    endcase
    if (fin) nst = last ? S_IDLE : S_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      c_cs   <= 4'd0;
      c_ws   <= 4'd0;
      c_act  <= 4'd1;
      c_hold <= 4'd0;
    end else if (cfg_wr) begin
      if (cfg_be[0]) begin
        en_q   <= cfg_wdata[0];
        c_hold <= cfg_wdata[7:4];
      end
      if (cfg_be[1]) begin
        c_act <= cfg_wdata[11:8];
        c_ws  <= cfg_wdata[15:12];
      end
      if (cfg_be[2]) c_cs <= cfg_wdata[19:16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_sw     <= 1'b0;
      tm_hwen   <= 1'b0;
      tm_unmask <= 1'b0;
      tm_rep    <= 1'b0;
      hw_arm    <= 1'b0;
      te_q      <= 1'b0;
    end else begin
      te_q <= te_in;
      if (trg_wr) begin
        tm_sw     <= trg_wdata[0];
        tm_hwen   <= trg_wdata[3];
        tm_unmask <= trg_wdata[4];
        tm_rep    <= trg_wdata[31];
        hw_arm    <= trg_wdata[3] & trg_wdata[4];
      end else if (start && hw_fire && !tm_rep) begin
        hw_arm <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= 4'd0;
      left       <= '0;
      t_cs       <= 4'd0;
      t_ws       <= 4'd0;
      t_act      <= 4'd0;
      t_hold     <= 4'd0;
      bus_q      <= '0;
      done_pulse <= 1'b0;
      done_flag  <= 1'b0;
    end else begin
      st         <= nst;
      cnt        <= ncnt;
      done_pulse <= fin & last;
      if (start) begin
        left   <= frame_n;
        t_cs   <= c_cs;
        t_ws   <= c_ws;
        t_act  <= c_act;
        t_hold <= c_hold;
      end else if (fin) begin
        left <= left - CNTW'(1);
      end
      if (st == S_LOAD && pix_valid) bus_q <= pix_data;
      if (fin && last)   done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/i80_wr_engine_chk.sv
module i80_wr_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_n,
  input logic          pix_ready,
  input logic          busy,
  input logic          done_pulse,
  input logic          done_flag,
  input logic [DW-1:0] bus_data
);
  // R4
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (cs_n && wr_n));

  // R3
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(bus_data));

  // R10
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_pulse);

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (done_flag && !busy));
endmodule

bind i80_wr_engine i80_wr_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .pix_ready(pix_ready),
  .busy(busy), .done_pulse(done_pulse), .done_flag(done_flag), .bus_data(bus_data)
);

// File: tb/sim_i80_wr_engine.sv
module sim_i80_wr_engine;
  localparam int CLK_T = 10;
  localparam int DW    = 16;
  localparam int DIMW  = 12;

  // {gap, cs, ws, act, hold, width[7:0], height[7:0]}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 4'd0,  4'd0, 4'd0, 4'd0,  8'd4, 8'd1},
    {1'b0, 4'd1,  4'd2, 4'd3, 4'd1,  8'd3, 8'd2},
    {1'b1, 4'd2,  4'd0, 4'd1, 4'd0,  8'd5, 8'd1},
    {1'b0, 4'd0,  4'd3, 4'd0, 4'd2,  8'd2, 8'd3},
    {1'b1, 4'd15, 4'd1, 4'd2, 4'd15, 8'd2, 8'd2},
    {1'b0, 4'd1,  4'd1, 4'd1, 4'd1,  8'd1, 8'd1}
  };

  logic clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [3:0]      cfg_be = 4'h0;
  logic [31:0]     cfg_wdata = '0;
  logic            trg_wr = 1'b0;
  logic [31:0]     trg_wdata = '0;
  logic [DIMW-1:0] frm_w = '0;
  logic [DIMW-1:0] frm_h = '0;
  logic            te_in = 1'b0;
  logic [DW-1:0]   pix_data;
  logic            pix_valid;
  logic            pix_ready, cs_n, wr_n, busy, done_pulse, done_flag;
  logic [DW-1:0]   bus_data;
  logic            done_clr = 1'b0;

  logic [DW-1:0] seed = 16'hA500;
  int   src_idx = 0;
  logic tick = 1'b0;
  logic src_on = 1'b1;
  logic gap = 1'b0;

  int total = 0;
  int bad = 0;

  int cs_lo = 0, wr_lo = 0, words = 0, dones = 0, data_bad = 0, wide = 0;
  logic prev_wr = 1'b1, prev_done = 1'b0;

  i80_wr_engine #(.DW(DW), .DIMW(DIMW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .trg_wr(trg_wr), .trg_wdata(trg_wdata), .frm_w(frm_w), .frm_h(frm_h), .te_in(te_in),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready), .cs_n(cs_n),
    .wr_n(wr_n), .bus_data(bus_data), .busy(busy), .done_pulse(done_pulse),
    .done_flag(done_flag), .done_clr(done_clr)
  );

  assign pix_data  = seed + DW'(src_idx);
  assign pix_valid = src_on && !(gap && tick);

  always @(posedge clk) begin
    tick <= ~tick;
    if (pix_valid && pix_ready) src_idx <= src_idx + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) cs_lo++;
      if (!wr_n) wr_lo++;
      if (!prev_wr && wr_n) begin
        if (bus_data !== seed + DW'(words)) data_bad++;
        words++;
      end
      if (done_pulse) dones++;
      if (done_pulse && prev_done) wide++;
      prev_wr   = wr_n;
      prev_done = done_pulse;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic trg_write(input logic [31:0] d);
    @(negedge clk);
    trg_wr = 1'b1; trg_wdata = d;
    @(negedge clk);
    trg_wr = 1'b0; trg_wdata = '0;
  endtask

  task automatic te_pulse();
    @(negedge clk); te_in = 1'b1;
    @(negedge clk); te_in = 1'b0;
  endtask

  task automatic wait_done(input int max);
    int d0 = dones;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (dones != d0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, w0, n0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n", int'(cs_n), 1);
    check("R1 wr_n", int'(wr_n), 1);
    check("R1 pix_ready", int'(pix_ready), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done_pulse", int'(done_pulse), 0);
    check("R1 done_flag", int'(done_flag), 0);

    // R2 trigger ignored while interface disabled
    frm_w = 12'd2; frm_h = 12'd1;
    c0 = cs_lo; d0 = dones;
    trg_write(32'h3);
    repeat (40) @(negedge clk);
    check("R2 disabled no strobe", cs_lo - c0, 0);
    check("R2 disabled no done", dones - d0, 0);

    // R1 default counts: enable via byte 0 only, active stays 1
    cfg_write(4'b0001, 32'h1);
    frm_w = 12'd1; frm_h = 12'd1;
    c0 = cs_lo; w0 = wr_lo;
    trg_write(32'h3);
    wait_done(100);
    check("R1 default wr low", wr_lo - w0, 2);
    check("R1 default cs low", cs_lo - c0, 2);

    // R3 R4 R5 R6 vector walk
    for (int i = 0; i < 6; i++) begin
      logic [32:0] v;
      int cs, ws, ac, ho, n;
      v  = VEC[i];
      cs = int'(v[31:28]); ws = int'(v[27:24]); ac = int'(v[23:20]); ho = int'(v[19:16]);
      n  = int'(v[15:8]) * int'(v[7:0]);
      gap = v[32];
      cfg_write(4'hF, {12'h0, v[31:28], v[27:24], v[23:20], v[19:16], 4'h1});
      frm_w = DIMW'(v[15:8]); frm_h = DIMW'(v[7:0]);
      c0 = cs_lo; w0 = wr_lo; n0 = words; d0 = dones;
      trg_write(32'h3);
      wait_done(4000);
      check("R5 words per frame", words - n0, n);
      check("R3 cs low cycles", cs_lo - c0, n * (cs + ws + ac + 1 + ho));
      check("R3 wr low cycles", wr_lo - w0, n * (ac + 1));
      check("R6 one frame started", dones - d0, 1);
      check("R4 data order", data_bad, 0);
    end
    gap = 1'b0;

    // R10 pulse width and sticky flag
    check("R10 pulse one cycle", wide, 0);
    check("R10 flag set", int'(done_flag), 1);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    @(negedge clk);
    check("R10 flag cleared", int'(done_flag), 0);

    // R6 command without software mode bit
    c0 = cs_lo; d0 = dones;
    trg_write(32'h2);
    repeat (60) @(negedge clk);
    check("R6 no mode no frame", dones - d0, 0);
    check("R6 no mode no strobe", cs_lo - c0, 0);

    // R5 zero-size frame ignored
    frm_w = 12'd0; frm_h = 12'd3;
    trg_write(32'h3);
    repeat (60) @(negedge clk);
    check("R5 zero size ignored", dones - d0, 0);

    // R9 requests while busy are dropped
    cfg_write(4'hF, 32'h0000_0331);
    frm_w = 12'd4; frm_h = 12'd1;
    n0 = words; d0 = dones;
    trg_write(32'h3);
    repeat (5) @(negedge clk);
    check("R9 busy during frame", int'(busy), 1);
    trg_write(32'h3);
    repeat (3) @(negedge clk);
    trg_write(32'h3);
    wait_done(400);
    repeat (60) @(negedge clk);
    check("R9 single frame", dones - d0, 1);
    check("R9 word count", words - n0, 4);

    // R7 TE start, one-shot, and gating bits
    cfg_write(4'hF, 32'h0000_0101);
    frm_w = 12'd2; frm_h = 12'd1;
    d0 = dones;
    trg_write(32'h18);
    te_pulse();
    wait_done(200);
    check("R7 TE starts frame", dones - d0, 1);
    te_pulse();
    repeat (60) @(negedge clk);
    check("R7 one-shot consumed", dones - d0, 1);
    d0 = dones;
    trg_write(32'h08);
    te_pulse();
    repeat (60) @(negedge clk);
    check("R7 masked TE ignored", dones - d0, 0);
    trg_write(32'h19);
    te_pulse();
    repeat (60) @(negedge clk);
    check("R7 TE ignored in sw mode", dones - d0, 0);

    // R8 repeat on every TE
    trg_write(32'h8000_0018);
    te_pulse();
    wait_done(200);
    te_pulse();
    wait_done(200);
    te_pulse();
    wait_done(200);
    check("R8 every TE starts", dones - d0, 3);

    // R11 mid-frame configuration change
    cfg_write(4'hF, 32'h0000_0001);
    frm_w = 12'd3; frm_h = 12'd1;
    w0 = wr_lo;
    trg_write(32'h3);
    repeat (2) @(negedge clk);
    cfg_write(4'hF, 32'h0000_0501);
    wait_done(400);
    check("R11 latched active count", wr_lo - w0, 3);
    w0 = wr_lo;
    frm_w = 12'd1;
    trg_write(32'h3);
    wait_done(400);
    check("R11 new count next frame", wr_lo - w0, 6);
    check("R4 data order final", data_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule